// File: doc/BRIEF.md
# Gram-Schmidt Weight Decorrelation Unit

This block takes one weight vector and removes from it, one after another, its projections onto a set of reference weight vectors that were already decorrelated. It then scales what is left to unit length. All values are 16-bit signed fixed point with 14 fractional bits, so 16384 stands for 1.0. A start pulse opens a load window. The vector to clean arrives element by element on one 16-bit stream. The reference vectors arrive back to back on a second 16-bit stream. The cleaned, normalised vector leaves on a single 16-bit output stream, one element per cycle.

The vector length (`DIM`) and the number of reference vectors (`NREF`) are parameters. The same unit serves two cases. It can decorrelate against vectors of its own sub-matrix, or against vectors taken from other sub-matrices. Which vectors are fed as references is chosen upstream. When the last element leaves, a flag reports whether every output element lies within a tolerance (`TOL`) of the element originally loaded. Iterative weight estimation uses this flag as its convergence test.

Top module: `gs_decorr`

## Requirements
- R1: After an accepted start, the unit takes exactly `DIM` elements from the vector stream and `NREF*DIM` elements from the reference stream. Reference element k of vector j has stream position j*DIM+k. The two streams may be interleaved or separated, and may have gaps. A valid strobe seen while the unit is idle has no effect on any result.
- R2: For each reference vector, the projection coefficient is the full-precision dot product with the current weight vector. It is rounded half-up at bit 14 and saturated to the range -32768..32767.
- R3: References are removed in stream order. Each element becomes sat(w - round(coef*r >> 14)). The next dot product uses the already updated vector.
- R4: Normalisation takes n = floor(sqrt(sum of w squared)) and the reciprocal q = floor(2^28 / n). Each output is sat(round(w*q >> 14)). A vector that is all zero gives all-zero outputs.
- R5: The result leaves as `DIM` consecutive cycles with `out_valid_o` high, element 0 first. `done_o` is high exactly on the cycle of the last element.
- R6: `busy_o` rises on the cycle after an accepted start and falls by the cycle `done_o` is high. A start pulse while busy is ignored.
- R7: `conv_o` is valid on the `done_o` cycle. It is 1 when every output element differs from the loaded input element by at most `TOL` (default 16), and 0 otherwise. It is 0 on all other cycles.
- R8: With `NREF` = 0, the output is the normalised input vector.
- R9: After reset, `out_valid_o`, `done_o`, `conv_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; opens the load window when idle |
| vec_valid_i | input | 1 | Element strobe for the vector to decorrelate |
| vec_data_i | input | W | Element of the vector to decorrelate |
| ref_valid_i | input | 1 | Element strobe for the reference stream |
| ref_data_i | input | W | Element of the reference vector sequence |
| out_valid_o | output | 1 | Output element strobe |
| out_data_o | output | W | Decorrelated, normalised element |
| done_o | output | 1 | High with the last output element |
| conv_o | output | 1 | Convergence flag, valid with done_o |
| busy_o | output | 1 | Unit is loading, computing or unloading |

## Verification
Assertions check four things on every cycle: the load counters never overrun their targets, `done_o` never appears without a valid element, a start while busy never reopens the load window, and the convergence flag only accompanies `done_o`. The square-root and reciprocal engines are also checked on every cycle: each result is asserted to be the exact floor value of its operand. The arithmetic itself can only be shown by the bench's scenarios, which compare each output element against an independent model. These scenarios cover the sequential projection removal, dot-product saturation, the zero-vector and converged cases, the no-reference variant, and idle or busy stimulus having no effect.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_DOT, S_COEF, S_SUB, S_SQ,
    S_ROOT, S_RWAIT, S_DIV, S_DWAIT, S_OUT
  } gs_state_e;

  // round half up at bit position f, arithmetic shift
  function automatic logic signed [63:0] rshr(input logic signed [63:0] x,
                                              input int unsigned f);
    return (x + (64'sd1 <<< (f - 1))) >>> f;
  endfunction

endpackage

// File: rtl/gs_isqrt.sv
module gs_isqrt #(
  parameter int SW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [SW-1:0] op_i,
  output logic          done_o,
  output logic [SW/2-1:0] root_o
);
  localparam int RW = SW / 2;
  localparam int CW = $clog2(RW + 1);

  logic          run_q, run_d, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] opsh_q, opsave_q;
  logic [RW+1:0] rem_q;
  logic [RW-1:0] root_q;
  logic [RW+2:0] rem_sh, trial, rem_sub;
  logic          ge;
  logic          last;

  assign rem_sh  = {rem_q[RW:0], opsh_q[SW-1:SW-2]};
  assign trial   = {1'b0, root_q, 2'b01};
  assign ge      = rem_sh >= trial;
  assign rem_sub = rem_sh - trial;
  assign last    = run_q && (cnt_q == CW'(RW - 1));

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (go_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      done_o <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (go_i) begin
      opsh_q   <= op_i;
      opsave_q <= op_i;
      rem_q    <= '0;
      root_q   <= '0;
    end else if (run_q) begin
      opsh_q <= opsh_q << 2;
      rem_q  <= ge ? rem_sub[RW+1:0] : rem_sh[RW+1:0];
      root_q <= {root_q[RW-2:0], ge};
    end
  end

  assign root_o = root_q;

  logic [SW+1:0] r_ext, sq_lo, sq_hi;
  assign r_ext = (SW+2)'(root_q);
  assign sq_lo = r_ext * r_ext;
  assign sq_hi = (r_ext + 1'b1) * (r_ext + 1'b1);

  // R4: the root is the exact floor square root of the latched operand
  assert_root_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sq_lo <= (SW+2)'(opsave_q)) && (sq_hi > (SW+2)'(opsave_q)));

endmodule

// File: rtl/gs_recip.sv
module gs_recip #(
  parameter int RW = 17,
  parameter int NW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [RW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  localparam int CW = $clog2(NW + 1);

  logic          run_q, run_d, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] nsh_q, quo_q;
  logic [RW:0]   rem_q, rem_sh, rem_sub;
  logic [RW-1:0] den_q;
  logic          ge;
  logic          last;

  assign rem_sh  = {rem_q[RW-1:0], nsh_q[NW-1]};
  assign ge      = rem_sh >= {1'b0, den_q};
  assign rem_sub = rem_sh - {1'b0, den_q};
  assign last    = run_q && (cnt_q == CW'(NW - 1));

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (go_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      done_o <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (go_i) begin
      nsh_q <= {1'b1, {(NW-1){1'b0}}};
      rem_q <= '0;
      quo_q <= '0;
      den_q <= den_i;
    end else if (run_q) begin
      nsh_q <= nsh_q << 1;
      rem_q <= ge ? rem_sub : rem_sh;
      quo_q <= {quo_q[NW-2:0], ge};
    end
  end

  assign quo_o = quo_q;

  localparam int PW = NW + RW + 1;
  logic [PW-1:0] p_lo, p_hi, numv;
  assign numv = PW'(1) << (NW - 1);
  assign p_lo = PW'(quo_q) * PW'(den_q);
  assign p_hi = (PW'(quo_q) + 1'b1) * PW'(den_q);

  // R4: the reciprocal is the exact floor quotient for a non-zero norm
  assert_recip_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && den_q != '0) |-> (p_lo <= numv) && (p_hi > numv));

endmodule

// File: rtl/gs_decorr.sv
module gs_decorr #(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int DIM  = 4,
  parameter int NREF = 2,
  parameter int TOL  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         vec_valid_i,
  input  logic [W-1:0] vec_data_i,
  input  logic         ref_valid_i,
  input  logic [W-1:0] ref_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         done_o,
  output logic         conv_o,
  output logic         busy_o
);
  import gs_pkg::*;

  localparam int IW   = (DIM > 1) ? $clog2(DIM) : 1;
  localparam int WCW  = $clog2(DIM + 1);
  localparam int RTOT = NREF * DIM;
  localparam int RN   = (NREF > 0) ? NREF : 1;
  localparam int RSZ  = RN * DIM;
  localparam int RAW  = (RSZ > 1) ? $clog2(RSZ) : 1;
  localparam int RCW  = (RTOT > 0) ? $clog2(RTOT + 1) : 1;
  localparam int JW   = (RN > 1) ? $clog2(RN) : 1;
  localparam int PW   = 2 * W;
  localparam int ACCW = PW + IW + 1;
  localparam int SW   = ((PW + IW + 1) / 2) * 2;
  localparam int RW   = SW / 2;
  localparam int NW   = 2 * FRAC + 1;
  localparam logic signed [63:0] MAXV = 64'((64'sd1 <<< (W - 1)) - 1);
  localparam logic signed [63:0] MINV = -MAXV - 64'sd1;
  localparam logic signed [63:0] TOLV = 64'(TOL);

  function automatic logic signed [W-1:0] satw(input logic signed [63:0] x);
    if (x > MAXV)      return MAXV[W-1:0];
    else if (x < MINV) return MINV[W-1:0];
    else               return x[W-1:0];
  endfunction

  gs_state_e state_q, state_d;
  logic [IW-1:0]  idx_q;
  logic [JW-1:0]  jdx_q;
  logic [WCW-1:0] wcnt_q;
  logic [RCW-1:0] rcnt_q;
  logic           conv_run_q;

  logic signed [W-1:0]    wv   [DIM];
  logic signed [W-1:0]    orig [DIM];
  logic signed [W-1:0]    refm [RSZ];
  logic signed [ACCW-1:0] acc_q;
  logic signed [W-1:0]    coef_q;

  logic          sq_done, dv_done;
  logic [RW-1:0] sq_root;
  logic [NW-1:0] dv_quo;

  logic last_el, last_ref, load_full;
  logic [RAW-1:0] raddr;
  logic signed [W-1:0]  rsel, wsel;
  logic signed [63:0]   mac, sub_term, sc_full, diff;
  logic signed [W-1:0]  coef_n, sub_n, sc;
  logic                 close;

  assign last_el   = (idx_q == IW'(DIM - 1));
  assign last_ref  = (int'(jdx_q) == NREF - 1);
  assign load_full = (wcnt_q == WCW'(DIM)) && (rcnt_q == RCW'(RTOT));
  assign raddr     = RAW'(int'(jdx_q) * DIM + int'(idx_q));
  assign rsel      = refm[raddr];
  assign wsel      = wv[idx_q];

  // shared multiply-accumulate operand: projection or squared norm
  assign mac      = (state_q == S_SQ) ? 64'(wsel) * 64'(wsel)
                                      : 64'(wsel) * 64'(rsel);
  assign coef_n   = satw(rshr(64'(acc_q), FRAC));
  assign sub_term = rshr(64'(coef_q) * 64'(rsel), FRAC);
  assign sub_n    = satw(64'(wsel) - sub_term);
  assign sc_full  = rshr(64'(wsel) * $signed({{(64-NW){1'b0}}, dv_quo}), FRAC);
  assign sc       = satw(sc_full);
  assign diff     = 64'(sc) - 64'(orig[idx_q]);
  assign close    = (diff <= TOLV) && (diff >= -TOLV);

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_LOAD;
      S_LOAD:  if (load_full) state_d = (NREF > 0) ? S_DOT : S_SQ;
      S_DOT:   if (last_el) state_d = S_COEF;
      S_COEF:  state_d = S_SUB;
      S_SUB:   if (last_el) state_d = last_ref ? S_SQ : S_DOT;
      S_SQ:    if (last_el) state_d = S_ROOT;
      S_ROOT:  state_d = S_RWAIT;
      S_RWAIT: if (sq_done) state_d = S_DIV;
      S_DIV:   state_d = S_DWAIT;
      S_DWAIT: if (dv_done) state_d = S_OUT;
      S_OUT:   if (last_el) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      jdx_q       <= '0;
      wcnt_q      <= '0;
      rcnt_q      <= '0;
      conv_run_q  <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      done_o      <= 1'b0;
      conv_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
      conv_o      <= 1'b0;
      if (state_q == S_IDLE && start_i) begin
        wcnt_q     <= '0;
        rcnt_q     <= '0;
        jdx_q      <= '0;
        idx_q      <= '0;
        conv_run_q <= 1'b1;
      end
      if (state_q == S_LOAD) begin
        if (vec_valid_i && wcnt_q < WCW'(DIM))  wcnt_q <= wcnt_q + 1'b1;
        if (ref_valid_i && rcnt_q < RCW'(RTOT)) rcnt_q <= rcnt_q + 1'b1;
      end
      if (state_q == S_DOT || state_q == S_SUB || state_q == S_SQ ||
          state_q == S_OUT) begin
        idx_q <= last_el ? '0 : idx_q + 1'b1;
      end
      if (state_q == S_SUB && last_el && !last_ref) jdx_q <= jdx_q + 1'b1;
      if (state_q == S_OUT) begin
        out_valid_o <= 1'b1;
        out_data_o  <= sc;
        conv_run_q  <= conv_run_q & close;
        done_o      <= last_el;
        conv_o      <= last_el & conv_run_q & close;
      end
    end
  end

  // datapath registers (no reset)
  always_ff @(posedge clk) begin
    if (state_q == S_LOAD) begin
      if (vec_valid_i && wcnt_q < WCW'(DIM)) begin
        wv[IW'(wcnt_q)]   <= vec_data_i;
        orig[IW'(wcnt_q)] <= vec_data_i;
      end
      if (ref_valid_i && rcnt_q < RCW'(RTOT)) refm[RAW'(rcnt_q)] <= ref_data_i;
    end
    if (state_q == S_LOAD || state_q == S_COEF) acc_q <= '0;
    else if (state_q == S_DOT || state_q == S_SQ) acc_q <= ACCW'(64'(acc_q) + mac);
    if (state_q == S_COEF) coef_q <= coef_n;
    if (state_q == S_SUB)  wv[idx_q] <= sub_n;
  end

  assign busy_o = (state_q != S_IDLE);

  gs_isqrt #(.SW(SW)) u_sqrt (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (state_q == S_ROOT),
    .op_i   (acc_q[SW-1:0]),
    .done_o (sq_done),
    .root_o (sq_root)
  );

  gs_recip #(.RW(RW), .NW(NW)) u_recip (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (state_q == S_DIV),
    .den_i  (sq_root),
    .done_o (dv_done),
    .quo_o  (dv_quo)
  );

  // R1: load counters never run past their targets
  assert_load_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt_q <= WCW'(DIM)) && (rcnt_q <= RCW'(RTOT)));

  // R5: done only together with an output element
  assert_done_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> out_valid_o);

  // R6: a start while computing never reopens the load window
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && state_q != S_LOAD && start_i) |=> state_q != S_LOAD);

  // R7: the convergence flag only accompanies done
  assert_conv_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> done_o);

endmodule

// File: tb/gs_decorr_tb.sv
module gs_decorr_tb;
  localparam int W = 16, FRAC = 14, DIM = 4, NREF = 2, TOL = 16;
  localparam int RT = NREF * DIM;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic start, vv, rv, start0, vv0;
  logic [W-1:0] vd, rd, vd0;
  logic ov, dn, cv, bz, ov0, dn0, cv0, bz0;
  logic signed [W-1:0] od, od0;

  gs_decorr #(.W(W), .FRAC(FRAC), .DIM(DIM), .NREF(NREF), .TOL(TOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .vec_valid_i(vv), .vec_data_i(vd), .ref_valid_i(rv), .ref_data_i(rd),
    .out_valid_o(ov), .out_data_o(od), .done_o(dn), .conv_o(cv), .busy_o(bz));

  gs_decorr #(.W(W), .FRAC(FRAC), .DIM(DIM), .NREF(0), .TOL(TOL)) u_dut0 (
    .clk(clk), .rst_n(rst_n), .start_i(start0),
    .vec_valid_i(vv0), .vec_data_i(vd0), .ref_valid_i(1'b0), .ref_data_i('0),
    .out_valid_o(ov0), .out_data_o(od0), .done_o(dn0), .conv_o(cv0), .busy_o(bz0));

  int total = 0, bad = 0, cyc = 0;
  int in_w [DIM];
  int in_r [RT];
  int exp_a [DIM];
  int exp_b [DIM];
  bit exp_ac, exp_bc, pend_a = 0, pend_b = 0;
  int oi_a = 0, oi_b = 0;
  string cur_req = "R3";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint rsh(input longint x);
    return (x + (longint'(1) << (FRAC - 1))) >>> FRAC;
  endfunction

  function automatic longint satv(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic longint isq(input longint s);
    longint r = 0;
    for (int b = 20; b >= 0; b--) begin
      longint t = r + (longint'(1) << b);
      if (t * t <= s) r = t;
    end
    return r;
  endfunction

  // behavioural reference: sequential projection removal then normalisation
  task automatic model(input int nref, input bit sel);
    longint w [DIM];
    longint s = 0, nrm, rc, o;
    bit c = 1;
    for (int i = 0; i < DIM; i++) w[i] = in_w[i];
    for (int j = 0; j < nref; j++) begin
      longint dot = 0, cf;
      for (int i = 0; i < DIM; i++) dot += w[i] * in_r[j*DIM+i];
      cf = satv(rsh(dot));
      for (int i = 0; i < DIM; i++) w[i] = satv(w[i] - rsh(cf * in_r[j*DIM+i]));
    end
    for (int i = 0; i < DIM; i++) s += w[i] * w[i];
    nrm = isq(s);
    rc = (nrm == 0) ? 0 : (longint'(1) << (2*FRAC)) / nrm;
    for (int i = 0; i < DIM; i++) begin
      o = satv(rsh(w[i] * rc));
      if (o - in_w[i] > TOL || in_w[i] - o > TOL) c = 0;
      if (sel) exp_b[i] = int'(o); else exp_a[i] = int'(o);
    end
    if (sel) exp_bc = c; else exp_ac = c;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (ov) begin
      if (!pend_a) check(0, "R5", "unexpected output element", 1, 0);
      else begin
        check(int'(od) == exp_a[oi_a], cur_req, "output element", od, exp_a[oi_a]);
        check(dn == (oi_a == DIM-1), "R5", "done placement", dn, oi_a == DIM-1);
        if (oi_a == DIM-1) begin
          check(cv == exp_ac, "R7", "convergence flag", cv, exp_ac);
          pend_a = 0; oi_a = 0;
        end else oi_a++;
      end
    end else if (dn || cv) check(0, "R5", "done/conv without element", dn, 0);
    if (ov0) begin
      if (!pend_b) check(0, "R8", "unexpected output element", 1, 0);
      else begin
        check(int'(od0) == exp_b[oi_b], "R8", "output element", od0, exp_b[oi_b]);
        check(dn0 == (oi_b == DIM-1), "R5", "done placement", dn0, oi_b == DIM-1);
        if (oi_b == DIM-1) begin
          check(cv0 == exp_bc, "R7", "convergence flag", cv0, exp_bc);
          pend_b = 0; oi_b = 0;
        end else oi_b++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "WD", "watchdog expired", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // mode 0: parallel streams, 1: references first with gaps, 2: as 0 plus start while busy
  task automatic run_a(input int mode, input string req);
    cur_req = req;
    model(NREF, 0);
    pend_a = 1; oi_a = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(bz == 1, "R6", "busy after start", bz, 1);
    if (mode == 1) begin
      for (int k = 0; k < RT; k++) begin
        @(negedge clk); rv = 1; rd = W'(in_r[k]);
        @(negedge clk); rv = 0;
      end
      for (int k = 0; k < DIM; k++) begin
        @(negedge clk); vv = 1; vd = W'(in_w[k]);
        @(negedge clk); vv = 0;
      end
    end else begin
      for (int k = 0; k < RT; k++) begin
        @(negedge clk);
        vv = (k < DIM); vd = (k < DIM) ? W'(in_w[k]) : '0;
        rv = 1; rd = W'(in_r[k]);
      end
      @(negedge clk); vv = 0; rv = 0;
    end
    if (mode == 2) begin
      repeat (3) @(negedge clk);
      start = 1; vv = 1; vd = 16'h1234; rv = 1; rd = 16'h4321;
      @(negedge clk); start = 0; vv = 0; rv = 0;
      check(bz == 1, "R6", "still busy after ignored start", bz, 1);
    end
    while (pend_a) @(negedge clk);
    check(bz == 0, "R6", "idle after done", bz, 0);
    if (mode == 2) begin
      repeat (12) @(negedge clk);
      check(bz == 0, "R6", "no restart from ignored start", bz, 0);
    end
  endtask

  task automatic run_b();
    model(0, 1);
    pend_b = 1; oi_b = 0;
    @(negedge clk); start0 = 1;
    @(negedge clk); start0 = 0;
    check(bz0 == 1, "R6", "busy after start", bz0, 1);
    for (int k = 0; k < DIM; k++) begin
      @(negedge clk); vv0 = 1; vd0 = W'(in_w[k]);
    end
    @(negedge clk); vv0 = 0;
    while (pend_b) @(negedge clk);
  endtask

  task automatic set_w(input int a, input int b, input int c, input int d);
    in_w[0] = a; in_w[1] = b; in_w[2] = c; in_w[3] = d;
  endtask

  task automatic set_r(input int j, input int a, input int b, input int c, input int d);
    in_r[j*DIM] = a; in_r[j*DIM+1] = b; in_r[j*DIM+2] = c; in_r[j*DIM+3] = d;
  endtask

  initial begin
    rst_n = 0; start = 0; vv = 0; rv = 0; vd = '0; rd = '0;
    start0 = 0; vv0 = 0; vd0 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ov == 0 && dn == 0 && cv == 0 && bz == 0, "R9", "reset outputs", {ov, dn, cv, bz}, 0);
    check(ov0 == 0 && bz0 == 0, "R9", "reset outputs no-ref", {ov0, bz0}, 0);

    // R3: one projection removed, second reference orthogonal
    set_w(8192, 8192, 0, 0); set_r(0, 16384, 0, 0, 0); set_r(1, 0, 0, 16384, 0);
    run_a(0, "R3");
    // R7: already orthogonal and unit length, flag set
    set_w(0, 0, 0, 16384); set_r(0, 16384, 0, 0, 0); set_r(1, 0, 16384, 0, 0);
    run_a(0, "R7");
    // R4: vector lies in reference span, all-zero result
    set_w(16384, 0, 0, 0);
    run_a(1, "R4");
    // R2: dot product saturates
    set_w(32767, 32767, 32767, 32767); set_r(0, 32767, 32767, 32767, 32767);
    set_r(1, -32768, 100, -5, 7);
    run_a(1, "R2");
    // R3: mixed signs, gapped references first
    set_w(1200, -3000, 7000, -250); set_r(0, 11585, 11585, 0, 0);
    set_r(1, 0, 0, 11585, -11585);
    run_a(1, "R3");
    // R1: strobes while idle have no effect
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); vv = 1; vd = W'(k * 999); rv = 1; rd = W'(-k * 77);
    end
    @(negedge clk); vv = 0; rv = 0;
    check(ov == 0 && bz == 0, "R1", "idle strobes ignored", {ov, bz}, 0);
    set_w(-5000, 2500, 400, 9000); set_r(0, 0, 11585, 11585, 0);
    set_r(1, 8192, 0, 0, 14189);
    run_a(0, "R1");
    // R6: start while busy ignored
    set_w(3000, -4000, 1000, 0);
    run_a(2, "R6");
    // R8: no references, plain normalisation
    set_w(3000, -4000, 0, 0);
    run_b();
    set_w(1, 0, 0, 0);
    run_b();
    set_w(0, 0, 0, 0);
    run_b();

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule